// File: doc/BRIEF.md
# Asynchronous Memory Write Sequencer

This block is a bus master that carries out write cycles to asynchronous external memory and to memory-mapped peripherals. An internal client presents one write at a time: an address, a data word and a bank index, handed over with a request/busy/done handshake. The sequencer then drives the external address, a one-hot active-low chip select, an active-low write strobe, a data output enable and a flag that says when another strobe may fall on the shared bus.

All timing is counted on a fast clock with four ticks per core-clock period, so one tick is a quarter of a core cycle. An external bus cycle is `CC_PER_BUS` core cycles long, which gives `TPB = 4*CC_PER_BUS` ticks. A wait-state count, an address-hold option and a bus-idle option are sampled when a write is accepted. The strobe is lengthened by whole bus cycles for each wait state. The acknowledge input is passed through a two-flop synchronizer. It is looked at only after the programmed wait states have run out, and a low value stretches the strobe by one more bus cycle each time it is sampled. The two options lengthen the hold of address and data after the strobe, and the recovery time before the next strobe, independently of each other.

Top module: `async_wr_seq`

## Requirements
- R1: While reset is held and right after it is released, the strobe is high, all selects are high, the data enable is low, `busy` is low and `bus_next_ok` is high.
- R2: With acknowledge high, the write strobe stays low for exactly `TPB-2 + W*TPB` ticks, where W is the wait-state count sampled when the request was accepted.
- R3: With W = 0 the acknowledge input has no effect: the strobe width is `TPB-2` ticks even if acknowledge stays low for the whole access.
- R4: With W > 0 the synchronized acknowledge is sampled on the last tick of the strobe window. Each low sample adds one window of `TPB` ticks, so the width is `TPB-2 + W*TPB + n*TPB` for n low samples.
- R5: Address and select become valid exactly one tick before the strobe falls. The address equals the request address, and only `bus_cs_n[k]` is low, where k is the request bank index.
- R6: The data enable rises on the same tick that the strobe falls, and `bus_data` equals the request data while the enable is high.
- R7: After the strobe rises, address, select and data enable stay driven for `1 + TPB` ticks when the hold option is set and for 1 tick when it is clear.
- R8: `bus_next_ok` rises exactly `2 + TPB*hold + TPB*idle` ticks after the strobe rises, and while it is high no strobe, select or data enable is active.
- R9: A request is accepted only while `bus_next_ok` is high. `busy` is high from the next tick until `bus_next_ok` returns, and `done` pulses for exactly one tick, on the last tick that address and data are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four ticks per core-clock period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Write request, taken when `bus_next_ok` is high |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_bank | input | BSW | Bank index selecting one chip select |
| busy | output | 1 | An access or its recovery is in progress |
| done | output | 1 | One-tick pulse at the end of the hold phase |
| cfg_wait | input | WW | Wait states, in bus cycles |
| cfg_hold | input | 1 | Add one bus cycle of address and data hold |
| cfg_idle | input | 1 | Add one bus cycle of bus idle before the next strobe |
| ack | input | 1 | Asynchronous acknowledge from the external device |
| bus_addr | output | AW | External address, zero when not driven |
| bus_cs_n | output | NBANK | Active-low one-hot chip selects |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_data | output | DW | Write data, zero when the enable is low |
| bus_data_oe | output | 1 | Data driver enable |
| bus_next_ok | output | 1 | Another strobe may fall on the bus |

## Verification
The bench builds the block with `CC_PER_BUS = 2`, which gives an 8-tick bus cycle, a 3-bit wait field and four banks. Eight ticks per bus cycle are enough to tell the quarter-core and half-core offsets apart from whole-cycle extensions. They also let the bench release acknowledge in the middle of a window, where the synchronizer delay cannot shift which sample sees it. With these values a full sweep of wait states 0 to 3 against all four hold/idle combinations is cheap. That sweep is run with acknowledge high, with acknowledge held low through two extra windows, and with acknowledge held low at zero wait states. Every width, hold and gap is then predicted from the tick formulas alone.

// File: rtl/async_wr_pkg.sv
package async_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_RECOV  = 3'd4
  } phase_t;

  // Strobe-low ticks before the first acknowledge sample.
  function automatic int strobe_ticks(int waits, int tpb);
    return tpb - 2 + waits * tpb;
  endfunction

  // Ticks address/select/data remain driven after the strobe rises.
  function automatic int hold_ticks(bit hold, int tpb);
    return 1 + (hold ? tpb : 0);
  endfunction

  // Ticks between end of hold and readiness for the next strobe.
  function automatic int recov_ticks(bit idle, int tpb);
    return 1 + (idle ? tpb : 0);
  endfunction

endpackage

// File: rtl/awseq_sync.sv
module awseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/awseq_timer.sv
module awseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              count <= '0;
    else if (load)           count <= load_val;
    else if (count != '0)    count <= count - 1'b1;

  assign expired = (count == '0);
endmodule

// File: rtl/async_wr_seq.sv
module async_wr_seq
  import async_wr_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int NBANK      = 4,
  parameter int BSW        = (NBANK > 1) ? $clog2(NBANK) : 1,
  parameter int WW         = 3,
  parameter int CC_PER_BUS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_data,
  input  logic [BSW-1:0]   req_bank,
  output logic             busy,
  output logic             done,
  input  logic [WW-1:0]    cfg_wait,
  input  logic             cfg_hold,
  input  logic             cfg_idle,
  input  logic             ack,
  output logic [AW-1:0]    bus_addr,
  output logic [NBANK-1:0] bus_cs_n,
  output logic             bus_wr_n,
  output logic [DW-1:0]    bus_data,
  output logic             bus_data_oe,
  output logic             bus_next_ok
);
  localparam int TPB = 4 * CC_PER_BUS;
  localparam int CW  = $clog2(((1 << WW) + 1) * TPB + 1);

  phase_t          phase, phase_d;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;
  logic [BSW-1:0]  bank_q;
  logic [WW-1:0]   wait_q;
  logic            hold_q, idle_q;
  logic            ack_s;
  logic            load;
  logic [CW-1:0]   load_val;
  logic            expired;

  // Named internal events, used by the assertions.
  logic accept, strobe_end, ack_stretch, addr_phase;

  awseq_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ack), .q(ack_s)
  );

  awseq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
  );

  assign accept      = (phase == PH_IDLE) && req;
  assign strobe_end  = (phase == PH_STROBE) && expired;
  assign ack_stretch = strobe_end && (wait_q != '0) && !ack_s;

  always_comb begin
    phase_d  = phase;
    load     = 1'b0;
    load_val = '0;
    unique case (phase)
      PH_IDLE: if (req) begin
        phase_d = PH_SETUP;
        load    = 1'b1;
      end
      PH_SETUP: if (expired) begin
        phase_d  = PH_STROBE;
        load     = 1'b1;
        load_val = CW'(strobe_ticks(int'(wait_q), TPB) - 1);
      end
      PH_STROBE: if (expired) begin
        load = 1'b1;
        if (ack_stretch) begin
          load_val = CW'(TPB - 1);
        end else begin
          phase_d  = PH_HOLD;
          load_val = CW'(hold_ticks(hold_q, TPB) - 1);
        end
      end
      PH_HOLD: if (expired) begin
        phase_d  = PH_RECOV;
        load     = 1'b1;
        load_val = CW'(recov_ticks(idle_q, TPB) - 1);
      end
      PH_RECOV: if (expired) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_q <= '0; data_q <= '0; bank_q <= '0;
      wait_q <= '0; hold_q <= 1'b0; idle_q <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr; data_q <= req_data; bank_q <= req_bank;
      wait_q <= cfg_wait; hold_q <= cfg_hold; idle_q <= cfg_idle;
    end

  assign addr_phase  = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign bus_wr_n    = (phase != PH_STROBE);
  assign bus_data_oe = (phase == PH_STROBE) || (phase == PH_HOLD);
  assign bus_addr    = addr_phase ? addr_q : '0;
  assign bus_data    = bus_data_oe ? data_q : '0;
  assign bus_next_ok = (phase == PH_IDLE);
  assign busy        = (phase != PH_IDLE);
  assign done        = (phase == PH_HOLD) && expired;

  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_cs
      assign bus_cs_n[b] = !(addr_phase && (bank_q == BSW'(b)));
    end
  endgenerate

  // ---------------- assertions ----------------
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> bus_wr_n && !bus_data_oe && bus_next_ok);

  p_ack_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_end && wait_q == '0) |=> (phase == PH_HOLD) && bus_wr_n);

  p_ack_stretch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stretch |=> !bus_wr_n);

  p_one_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  p_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> (bus_cs_n != '1) && $stable(bus_cs_n) && $stable(bus_addr));

  p_oe_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> bus_data_oe);

  p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_data_oe && $past(bus_data_oe)) |-> $stable(bus_data));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> (bus_cs_n != '1) && bus_data_oe);

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_next_ok |-> bus_wr_n && !bus_data_oe && (bus_cs_n == '1));

  p_done_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !bus_next_ok && !bus_data_oe);

endmodule

// File: tb/sim_async_wr_seq.sv
module sim_async_wr_seq;
  localparam int AW = 16, DW = 16, NBANK = 4, BSW = 2, WW = 3, CCB = 2;
  localparam int TPB = 4 * CCB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, ack = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [BSW-1:0] req_bank = '0;
  logic [WW-1:0] cfg_wait = '0;
  logic cfg_hold = 1'b0, cfg_idle = 1'b0;
  logic busy, done, bus_wr_n, bus_data_oe, bus_next_ok;
  logic [AW-1:0] bus_addr;
  logic [NBANK-1:0] bus_cs_n;
  logic [DW-1:0] bus_data;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  async_wr_seq #(.AW(AW), .DW(DW), .NBANK(NBANK), .BSW(BSW), .WW(WW), .CC_PER_BUS(CCB)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_data(req_data),
    .req_bank(req_bank), .busy(busy), .done(done), .cfg_wait(cfg_wait),
    .cfg_hold(cfg_hold), .cfg_idle(cfg_idle), .ack(ack), .bus_addr(bus_addr),
    .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_data(bus_data),
    .bus_data_oe(bus_data_oe), .bus_next_ok(bus_next_ok)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One write; m = acknowledge low samples wanted, low_all = hold ack low throughout.
  task automatic run_write(int w, bit h, bit i, int m, bit low_all, int bank);
    int t = 0, t_csf = -1, t_wf = -1, t_wr = -1, t_oer = -1, t_oef = -1;
    int t_csr = -1, t_nok = -1, t_done = -1, dones = 0, busy1 = 0;
    int base = TPB - 2 + w * TPB;
    int hold = 1 + (h ? TPB : 0);
    int width = (w == 0) ? base : base + m * TPB;
    logic p_wr = 1'b1, p_oe = 1'b0;
    logic p_cs_idle = 1'b1;
    logic [AW-1:0] a = AW'(16'h1000 + w * 16'h111 + bank * 16'h20 + (h ? 3 : 0) + (i ? 5 : 0));
    logic [DW-1:0] d = ~a ^ DW'(m);
    logic [NBANK-1:0] exp_cs = ~(NBANK'(1) << bank);
    @(negedge clk);
    cfg_wait = WW'(w); cfg_hold = h; cfg_idle = i;
    req_addr = a; req_data = d; req_bank = BSW'(bank);
    ack = (m > 0 || low_all) ? 1'b0 : 1'b1;
    req = 1'b1;
    while (t_nok < 0 && t < 1000) begin
      @(negedge clk);
      t++;
      if (t == 1) begin
        req = 1'b0;
        busy1 = int'(busy);
      end
      if (done) begin dones++; t_done = t; end
      if (p_cs_idle && bus_cs_n != '1) t_csf = t;
      if (!p_cs_idle && bus_cs_n == '1) t_csr = t;
      if (p_wr && !bus_wr_n) begin
        t_wf = t;
        chk("R5 address at strobe fall", int'(bus_addr), int'(a));
        chk("R5 select pattern", int'(bus_cs_n), int'(exp_cs));
        chk("R6 data at strobe fall", int'(bus_data), int'(d));
      end
      if (!p_wr && bus_wr_n) t_wr = t;
      if (!p_oe && bus_data_oe) t_oer = t;
      if (p_oe && !bus_data_oe) t_oef = t;
      if (t_wr >= 0 && bus_next_ok) t_nok = t;
      if (m > 0 && t_wf >= 0 && (t - t_wf) == base + m * TPB - TPB / 2) ack = 1'b1;
      p_wr = bus_wr_n; p_oe = bus_data_oe; p_cs_idle = (bus_cs_n == '1);
    end
    ack = 1'b1;
    if (w == 0 && low_all)
      chk("R3 width with ack ignored", t_wr - t_wf, width);
    else if (m > 0)
      chk("R4 width with ack stretch", t_wr - t_wf, width);
    else
      chk("R2 strobe width", t_wr - t_wf, width);
    chk("R5 select before strobe", t_wf - t_csf, 1);
    chk("R6 enable with strobe", t_oer - t_wf, 0);
    chk("R7 select hold", t_csr - t_wr, hold);
    chk("R7 data hold", t_oef - t_wr, hold);
    chk("R8 next strobe gap", t_nok - t_wr, 2 + (h ? TPB : 0) + (i ? TPB : 0));
    chk("R9 busy after accept", busy1, 1);
    chk("R9 single done", dones, 1);
    chk("R9 done position", t_done - t_wr, hold - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 strobe in reset", int'(bus_wr_n), 1);
    chk("R1 selects in reset", int'(bus_cs_n), (1 << NBANK) - 1);
    chk("R1 enable in reset", int'(bus_data_oe), 0);
    chk("R1 next_ok in reset", int'(bus_next_ok), 1);
    chk("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'(bus_next_ok && !busy && bus_wr_n), 1);
    for (int w = 0; w < 4; w++)
      for (int hi = 0; hi < 4; hi++) begin
        run_write(w, hi[0], hi[1], 0, 1'b0, (w + hi) % NBANK);
        if (w > 0) run_write(w, hi[0], hi[1], 2, 1'b0, hi % NBANK);
        else       run_write(0, hi[0], hi[1], 0, 1'b1, (hi + 1) % NBANK);
      end
    run_write(7, 1'b1, 1'b1, 1, 1'b0, 3);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule